// File: doc/BRIEF.md
# Shared Clock Stuck-Low Watchdog

Several devices share one wired-AND clock line and use it to keep their timing aligned. When a fault holds that line low, each device could recover at its own moment and the group would fall out of step. This block watches the sampled level of the line. If the level stays low for longer than a detection window, the block pulls the line low itself for a long, fixed hold interval. Every device on the line therefore sees at least one full minimum retry-delay event, and all of them leave it together.

The line level passes through a short synchronizer, and a counter measures how long it stays low. A detection starts the hold timer, which drives the open-drain pull-down enable, and sets a sticky stuck-low flag. The flag stays set until a clear strobe arrives. The low counter is stopped while the block drives the line, and it starts from zero once the pull-down is released. Both windows are set in microseconds and converted to clock cycles from the clock frequency parameter. With the defaults of 50 MHz, 64 µs and 120 ms, the windows are 3200 and 6,000,000 cycles.

Top module: `sclk_stuck_guard`

## Requirements
- R1: After a clock edge with `rst_n` low, `pull_low_o` and `stuck_o` are both 0.
- R2: The detection window is DETECT_CYC = CLK_KHZ*DETECT_US/1000 cycles. If `line_i` is sampled low at DETECT_CYC+1 consecutive rising edges k to k+DETECT_CYC, then `pull_low_o` and `stuck_o` become 1 after edge k+DETECT_CYC+SYNC_STAGES, and not before.
- R3: A high sample at any edge restarts the measurement. A low run of only DETECT_CYC samples causes no detection.
- R4: The hold length is HOLD_CYC = CLK_KHZ*HOLD_US/1000. Once raised, `pull_low_o` stays 1 for exactly HOLD_CYC cycles and then returns to 0.
- R5: While `pull_low_o` is 1, the level of `line_i` is ignored. It neither extends nor restarts the hold.
- R6: After the release, a new detection needs a fresh low run. If the line is still held low externally, `pull_low_o` stays 0 for exactly DETECT_CYC+1 cycles and then rises again.
- R7: `stuck_o` stays 1 when the hold ends. It returns to 0 only after an edge at which `clr_i` is 1 and no new detection occurs.
- R8: If `clr_i` is 1 at the same edge as a detection, the detection wins and `stuck_o` is 1 after that edge.
- R9: `clr_i` has no effect on `pull_low_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock of frequency CLK_KHZ kHz |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Level of the shared clock line (asynchronous) |
| clr_i | input | 1 | Clear strobe for the stuck-low flag |
| pull_low_o | output | 1 | Enable for the open-drain pull-down on the line |
| stuck_o | output | 1 | Sticky stuck-low status flag |

## Verification
A clear request and a new detection can fall on the same edge. The flag must then be set, not cleared. The bench keeps the line held low by external stimulus and uses its reference model to predict the edge at which the low counter expires. It pulses `clr_i` exactly on that edge and expects both outputs high after it. The opposite ordering is also tested: a clear pulsed during an active hold must drop the flag and leave the pull-down untouched.

// File: rtl/sclk_guard_pkg.sv
// Shared definitions for the shared-clock stuck-low watchdog.
// Assumes the parameters give windows of at least one cycle.
package sclk_guard_pkg;

    // Phase of the guard: watching the line, or holding it low.
    typedef enum logic {
        GUARD_WATCH = 1'b0,
        GUARD_HOLD  = 1'b1
    } guard_phase_t;

    // Convert a window in microseconds to cycles of a clk_khz clock.
    function automatic int unsigned us_to_cycles(input int unsigned clk_khz,
                                                 input int unsigned win_us);
        longint unsigned prod;
        prod = longint'(clk_khz) * longint'(win_us);
        return int'(prod / 64'd1000);
    endfunction

endpackage

// File: rtl/sclk_line_sync.sv
// Synchronizer chain for the asynchronous shared-clock line level.
// Assumes STAGES >= 1. The chain resets to 1, the idle level of the line.
module sclk_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Capture the line in a single register.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= 1'b1;
                else        chain_q <= async_i;
            end
        end else begin : g_multi
            // Shift the line level through the synchronizer stages.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/sclk_low_timer.sv
// Measures how long the synchronized line stays low.
// The expired pulse fires when the line is low at the sample after LIMIT
// counted low samples, which is "longer than the window".
// The count is held at zero while run_en is low, that is while this block drives the line.
module sclk_low_timer #(
    parameter int unsigned LIMIT = 3200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic line_low,
    output logic expired_o
);

    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign expired_o = run_en && line_low && (cnt_q == CW'(LIMIT));

    // Count consecutive low samples; restart on high, on expiry and when paused.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   cnt_q <= '0;
        else if (!run_en || !line_low || expired_o)   cnt_q <= '0;
        else                                          cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/sclk_hold_timer.sv
// Holds the pull-down active for exactly LEN cycles after a start pulse.
// Start pulses are ignored while a hold is running. Assumes LEN >= 1.
module sclk_hold_timer
    import sclk_guard_pkg::*;
#(
    parameter int unsigned LEN = 6000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o
);

    localparam int unsigned HW = (LEN > 1) ? $clog2(LEN) : 1;

    guard_phase_t  phase_q;
    logic [HW-1:0] left_q;

    // Move between watch and hold phases and count down the hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= GUARD_WATCH;
            left_q  <= '0;
        end else begin
            case (phase_q)
                GUARD_WATCH: begin
                    if (start_i) begin
                        phase_q <= GUARD_HOLD;
                        left_q  <= HW'(LEN - 1);
                    end
                end
                GUARD_HOLD: begin
                    if (left_q == '0) phase_q <= GUARD_WATCH;
                    else              left_q  <= left_q - 1'b1;
                end
                default: phase_q <= GUARD_WATCH;
            endcase
        end
    end

    assign active_o = (phase_q == GUARD_HOLD);

endmodule

// File: rtl/sclk_stuck_flag.sv
// Sticky status bit. Set has priority over clear in the same cycle.
module sclk_stuck_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    // Keep the flag until an explicit clear; a set in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end

endmodule

// File: rtl/sclk_stuck_guard.sv
// Top level of the shared-clock stuck-low watchdog.
// Synchronizes the line, measures its low time, and on a stuck condition
// drives the pull-down for a fixed hold and sets a sticky flag.
// Assumes clk runs at CLK_KHZ kHz and both windows convert to at least 1 cycle.
module sclk_stuck_guard
    import sclk_guard_pkg::*;
#(
    parameter int unsigned CLK_KHZ     = 50000,
    parameter int unsigned DETECT_US   = 64,
    parameter int unsigned HOLD_US     = 120000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic clr_i,
    output logic pull_low_o,
    output logic stuck_o
);

    localparam int unsigned DETECT_CYC = us_to_cycles(CLK_KHZ, DETECT_US);
    localparam int unsigned HOLD_CYC   = us_to_cycles(CLK_KHZ, HOLD_US);

    logic line_s;
    logic hit;
    logic holding;

    sclk_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_i),
        .sync_o  (line_s)
    );

    sclk_low_timer #(.LIMIT(DETECT_CYC)) u_low (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (!holding),
        .line_low  (!line_s),
        .expired_o (hit)
    );

    sclk_hold_timer #(.LEN(HOLD_CYC)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (hit),
        .active_o (holding)
    );

    sclk_stuck_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hit),
        .clr_i  (clr_i),
        .flag_o (stuck_o)
    );

    assign pull_low_o = holding;

endmodule

// File: rtl/sclk_stuck_guard_chk.sv
// Port-level checker for sclk_stuck_guard, attached with bind.
module sclk_stuck_guard_chk
    import sclk_guard_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 50000,
    parameter int unsigned HOLD_US = 120000
) (
    input logic clk,
    input logic rst_n,
    input logic clr_i,
    input logic pull_low_o,
    input logic stuck_o
);

    localparam int unsigned HOLD_CYC = us_to_cycles(CLK_KHZ, HOLD_US);
    localparam int unsigned RW       = $clog2(HOLD_CYC + 2);

    logic [RW-1:0] run_q;

    // Length of the current pull-down run, saturating just above the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                             run_q <= '0;
        else if (!pull_low_o)                   run_q <= '0;
        else if (run_q <= RW'(HOLD_CYC))        run_q <= run_q + 1'b1;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!pull_low_o && !stuck_o));

    // R4
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_low_o) |-> (run_q == RW'(HOLD_CYC)));

    // R5
    no_overlong_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(HOLD_CYC));

    // R8
    pull_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_low_o) |-> stuck_o);

    // R2
    flag_only_on_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stuck_o) |-> $rose(pull_low_o));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stuck_o && !clr_i) |=> stuck_o);

endmodule

bind sclk_stuck_guard sclk_stuck_guard_chk #(
    .CLK_KHZ (CLK_KHZ),
    .HOLD_US (HOLD_US)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .pull_low_o (pull_low_o),
    .stuck_o    (stuck_o)
);

// File: tb/test_sclk_stuck_guard.sv
module test_sclk_stuck_guard;

    localparam int unsigned CLK_KHZ = 1000;
    localparam int unsigned DET_US  = 12;
    localparam int unsigned HOLD_US = 40;
    localparam int unsigned SYNC    = 2;
    localparam int D = CLK_KHZ * DET_US / 1000;
    localparam int H = CLK_KHZ * HOLD_US / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_low = 1'b0;
    logic clr = 1'b0;
    logic line_w;
    logic pull_low;
    logic stuck;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Reference model state
    bit m_sync [SYNC];
    int m_lcnt, m_hcnt;
    bit m_hold, m_flag;

    always #10 clk = ~clk;

    assign line_w = (ext_low || pull_low) ? 1'b0 : 1'b1;

    sclk_stuck_guard #(
        .CLK_KHZ(CLK_KHZ), .DETECT_US(DET_US), .HOLD_US(HOLD_US), .SYNC_STAGES(SYNC)
    ) i_sclk_stuck_guard (
        .clk(clk), .rst_n(rst_n), .line_i(line_w), .clr_i(clr),
        .pull_low_o(pull_low), .stuck_o(stuck)
    );

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            summary();
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic bit model_detect_next();
        return !m_hold && !m_sync[SYNC-1] && (m_lcnt == D);
    endfunction

    // Advance the reference model by one edge from the pre-edge inputs.
    task automatic model_step(input bit rst, input bit ext, input bit c);
        bit ln, s, det;
        ln  = ext ? 1'b0 : !m_hold;
        s   = m_sync[SYNC-1];
        det = model_detect_next();
        if (rst) begin
            m_lcnt = 0; m_hcnt = 0; m_hold = 0; m_flag = 0;
            for (int i = 0; i < SYNC; i++) m_sync[i] = 1'b1;
        end else begin
            if (m_hold) begin
                if (m_hcnt == 0) m_hold = 0; else m_hcnt--;
                m_lcnt = 0;
            end else if (det) begin
                m_hold = 1; m_hcnt = H - 1; m_lcnt = 0;
            end else if (!s) m_lcnt++;
            else m_lcnt = 0;
            if (det) m_flag = 1; else if (c) m_flag = 0;
            for (int i = SYNC - 1; i > 0; i--) m_sync[i] = m_sync[i-1];
            m_sync[0] = ln;
        end
    endtask

    // One clock: drive inputs, take the edge, compare at the falling edge.
    task automatic cyc(input bit ext, input bit c);
        bit r;
        ext_low = ext;
        clr = c;
        r = !rst_n;
        @(posedge clk);
        model_step(r, ext, c);
        @(negedge clk);
        check(m_hold ? "R4 pull_low" : "R2 pull_low", int'(pull_low), int'(m_hold));
        check("R7 stuck", int'(stuck), int'(m_flag));
    endtask

    initial begin
        int n;
        int len;
        bit lv;
        void'($urandom(32'h5C1C0DE));
        for (int i = 0; i < SYNC; i++) m_sync[i] = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) cyc(0, 0);
        // R1 reset state
        check("R1 pull_low after reset", int'(pull_low), 0);
        check("R1 stuck after reset", int'(stuck), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) cyc(0, 0);

        // R3: only D low samples, then high
        for (int i = 0; i < D; i++) cyc(1, 0);
        for (int i = 0; i < SYNC + 4; i++) cyc(0, 0);
        check("R3 no detect on short low", int'(pull_low), 0);

        // R2: D+1 low samples, output after edge k+D+SYNC
        for (int i = 0; i < D + 1; i++) cyc(1, 0);
        for (int i = 0; i < SYNC - 1; i++) cyc(0, 0);
        check("R2 not early", int'(pull_low), 0);
        cyc(0, 0);
        check("R2 pull_low on time", int'(pull_low), 1);
        check("R2 stuck on time", int'(stuck), 1);

        // R4/R5/R9: hold length with random line activity and a no-op clear check
        n = 1;
        while (pull_low && n < H + 10) begin
            cyc(1'($urandom_range(1)), 0);
            if (pull_low) n++;
        end
        check("R4 R5 hold length", n, H);
        for (int i = 0; i < 3; i++) cyc(0, 0);
        check("R7 stuck after hold", int'(stuck), 1);
        cyc(0, 1);
        check("R7 stuck cleared", int'(stuck), 0);

        // R6: line held low through release; gap is D+1 cycles
        for (int i = 0; i < D + SYNC + 1; i++) cyc(1, 0);
        check("R6 first hold", int'(pull_low), 1);
        // R9: clear during hold drops flag, keeps pull-down
        cyc(1, 1);
        check("R9 pull_low unaffected by clear", int'(pull_low), 1);
        check("R7 clear during hold", int'(stuck), 0);
        while (pull_low) cyc(1, 0);
        n = 1;
        while (!pull_low && n < D + 20) begin
            cyc(1, 0);
            if (!pull_low) n++;
        end
        check("R6 fresh low gap", n, D + 1);

        // R8: clear on the detection edge
        while (pull_low) cyc(1, 0);
        cyc(1, 1);
        check("R7 clear after hold", int'(stuck), 0);
        while (!model_detect_next()) cyc(1, 0);
        cyc(1, 1);
        check("R8 set wins over clear", int'(stuck), 1);
        check("R8 pull_low on collision", int'(pull_low), 1);
        while (pull_low) cyc(0, 0);

        // Random phase: low and high runs around the window, sparse clears
        for (int k = 0; k < 120; k++) begin
            len = $urandom_range(2 * D + 2, 1);
            lv  = 1'($urandom_range(1));
            for (int i = 0; i < len; i++)
                cyc(lv, ($urandom_range(15) == 0));
        end

        summary();
        $finish;
    end

endmodule